// File: doc/BRIEF.md
# NOR Flash Command Sequencer

This block sits between a request source and a parallel NOR flash device. It expands each high-level request into the string of bus cycles that the flash command set expects. Most requests start with the two-cycle unlock prefix, followed by the command-specific cycles, and some end with reads of identification or query words. A request carries an opcode, a word address, a word count and one data word. The buffered program request takes its remaining data words, one per handshake, through the same valid/ready port.

Every bus cycle holds its address and write data steady for `HOLD` clocks. The read or write strobe is raised for `PULSE` clocks, starting after one setup clock. Words read during identification and query requests come back on a one-cycle result strobe. While an operation runs, the block reports busy and refuses further requests with a same-cycle negative acknowledge. Requests that cannot be executed are accepted and then flagged with an error pulse, and no bus activity follows. Waiting for the flash to finish an erase or a program is handled by a separate block.

Top module: `nor_cmd_seq`

## Requirements
- R1: After reset, `busy` is 0, `reqReady` is 1, and `busWe`, `busRe`, `rdValid` and `reqErr` are 0.
- R2: Only one strobe is high at a time. Each strobe stays high for exactly `PULSE` consecutive clocks. Address and write data do not change while a strobe is high.
- R3: Opcode 0 (return to read array) issues one write: data 0xF0 to word address 0.
- R4: Opcode 1 (read ID) issues three writes: 0xAA to 0x555, 0x55 to 0x2AA, and 0x90 to 0x555. It then reads word addresses 0x0, 0x1, 0xE and 0xF in that order. Each read word is returned on `rdData` with `rdValid` high.
- R5: Opcode 2 (single program) issues 0xAA to 0x555, 0x55 to 0x2AA and 0xA0 to 0x555. It then writes `reqData` to the request address.
- R6: Opcode 3 (buffered program, count N) issues the unlock pair, then 0x25 to the start address, then N-1 to the start address. Next come N writes of the data words, taken from N later handshakes, to the start address plus 0 through N-1. The last write is 0x29 to the start address plus N-1.
- R7: Opcode 4 (sector erase) issues 0xAA to 0x555, 0x55 to 0x2AA, 0x80 to 0x555, 0xAA to 0x555 and 0x55 to 0x2AA. It then writes 0x30 to the request address.
- R8: Opcode 5 (chip erase) issues the same first five writes as R7. Its sixth write is 0x10 to 0x555.
- R9: Opcode 6 (query) writes 0x98 to word address 0x55. It then reads word addresses 0x10 through 0x13 in order and returns each word on `rdData`.
- R10: While an operation runs and no data word is awaited, `reqReady` is 0. A request held valid in that state raises `reqNack` and adds no bus cycle.
- R11: Opcode 7, or opcode 3 with a count of 0 or above `MAX_BUF`, is accepted and then raises `reqErr` on the next clock. Such a request leaves `busy` at 0 and causes no bus cycle.
- R12: The bus carries byte addresses: the byte address of each cycle is its word address shifted left by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request or data-word beat valid |
| reqReady | output | 1 | Beat accepted on this clock when valid |
| reqOp | input | 3 | Opcode (0 to 7, see R3 to R11) |
| reqAddr | input | AW | Target word address |
| reqCount | input | CW | Word count for buffered program |
| reqData | input | 16 | Program data or buffered data word |
| reqNack | output | 1 | Beat refused because an operation is running |
| reqErr | output | 1 | Pulse one clock after an unexecutable request |
| busy | output | 1 | Operation in progress |
| busAddr | output | AW+1 | Flash byte address |
| busWrData | output | 16 | Flash write data |
| busWe | output | 1 | Write strobe, active high |
| busRe | output | 1 | Read strobe, active high |
| busRdData | input | 16 | Flash read data |
| rdValid | output | 1 | Read word available |
| rdData | output | 16 | Read word |

## Verification
The bench aims at the operations whose prefixes share cycles: read ID, sector erase and chip erase. A sequencer that mixed up the sixth cycle or the step order would put a wrong address or data word on the bus at a known position. For buffered programs, the bench uses counts of 1, 3 and the maximum. An off-by-one in the word counter would show up as a missing or extra data write, a wrong count-minus-one word, or a confirm sent to the wrong address. The bench drives a request while an erase is running, then a count of zero, a count of one over the maximum and the undefined opcode. A design that leaked any of these onto the bus would produce a cycle the reference model does not expect.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

  typedef enum logic [2:0] {
    OP_RESET = 3'd0,
    OP_ID    = 3'd1,
    OP_PROG  = 3'd2,
    OP_BUF   = 3'd3,
    OP_SECT  = 3'd4,
    OP_CHIP  = 3'd5,
    OP_CFI   = 3'd6,
    OP_BAD   = 3'd7
  } opT;

  typedef enum logic [1:0] {A_CMD, A_TGT, A_WORD, A_LAST} addrSelT;
  typedef enum logic [1:0] {D_CONST, D_CNTM1, D_WORD, D_REQ} dataSelT;

  typedef struct packed {
    logic       latch;
    logic       start;
    logic       isRead;
    addrSelT    aSel;
    dataSelT    dSel;
    logic [11:0] cmdAddr;
    logic [7:0]  cmdData;
    logic       loadWord;
    logic       incWord;
  } ctlStrobeT;

  localparam logic [11:0] ADR_KEY1  = 12'h555;
  localparam logic [11:0] ADR_KEY2  = 12'h2AA;
  localparam logic [11:0] ADR_QUERY = 12'h055;
  localparam logic [11:0] ADR_QBASE = 12'h010;
  localparam logic [7:0]  DAT_KEY1  = 8'hAA;
  localparam logic [7:0]  DAT_KEY2  = 8'h55;
  localparam logic [7:0]  DAT_ARRAY = 8'hF0;
  localparam logic [7:0]  DAT_IDENT = 8'h90;
  localparam logic [7:0]  DAT_WORD  = 8'hA0;
  localparam logic [7:0]  DAT_ERSET = 8'h80;
  localparam logic [7:0]  DAT_SECT  = 8'h30;
  localparam logic [7:0]  DAT_CHIP  = 8'h10;
  localparam logic [7:0]  DAT_QUERY = 8'h98;
  localparam logic [7:0]  DAT_BLOAD = 8'h25;
  localparam logic [7:0]  DAT_BCONF = 8'h29;

endpackage

// File: rtl/nor_seq_ctrl.sv
module nor_seq_ctrl
  import nor_seq_pkg::*;
#(
  parameter int CW      = 6,
  parameter int MAX_BUF = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqValid,
  input  logic [2:0]    reqOp,
  input  logic [CW-1:0] reqCount,
  input  logic          cycDone,
  input  logic          wordLast,
  output logic          reqReady,
  output logic          reqNack,
  output logic          reqErr,
  output logic          busy,
  output ctlStrobeT     ctl
);

  typedef enum logic [1:0] {S_IDLE, S_LAUNCH, S_RUN, S_WAITW} stT;

  stT       state, stateNx;
  logic [2:0] step, stepNx;
  opT       opReg;
  logic     errQ;
  logic     badReq;

  logic        siRead, siLast;
  addrSelT     siA;
  dataSelT     siD;
  logic [11:0] siCA;
  logic [7:0]  siCD;

  assign badReq = (reqOp == 3'd7) ||
                  ((reqOp == 3'd3) && ((reqCount == '0) || (int'(reqCount) > MAX_BUF)));

  // step table: what each step of the latched operation puts on the bus
  always_comb begin
    siRead = 1'b0;
    siLast = 1'b0;
    siA    = A_CMD;
    siD    = D_CONST;
    siCA   = 12'h000;
    siCD   = 8'h00;
    if ((opReg inside {OP_ID, OP_PROG, OP_BUF, OP_SECT, OP_CHIP}) && (step < 3'd2)) begin
      siCA = (step == 3'd0) ? ADR_KEY1 : ADR_KEY2;
      siCD = (step == 3'd0) ? DAT_KEY1 : DAT_KEY2;
    end else begin
      case (opReg)
        OP_RESET: begin
          siCD   = DAT_ARRAY;
          siLast = 1'b1;
        end
        OP_ID: begin
          if (step == 3'd2) begin
            siCA = ADR_KEY1;
            siCD = DAT_IDENT;
          end else begin
            siRead = 1'b1;
            case (step)
              3'd3:    siCA = 12'h000;
              3'd4:    siCA = 12'h001;
              3'd5:    siCA = 12'h00E;
              default: siCA = 12'h00F;
            endcase
            siLast = (step == 3'd6);
          end
        end
        OP_PROG: begin
          if (step == 3'd2) begin
            siCA = ADR_KEY1;
            siCD = DAT_WORD;
          end else begin
            siA    = A_TGT;
            siD    = D_REQ;
            siLast = 1'b1;
          end
        end
        OP_BUF: begin
          case (step)
            3'd2: begin siA = A_TGT;  siCD = DAT_BLOAD; end
            3'd3: begin siA = A_TGT;  siD  = D_CNTM1;   end
            3'd4: begin siA = A_WORD; siD  = D_WORD;    end
            default: begin
              siA    = A_LAST;
              siCD   = DAT_BCONF;
              siLast = 1'b1;
            end
          endcase
        end
        OP_SECT, OP_CHIP: begin
          case (step)
            3'd2: begin siCA = ADR_KEY1; siCD = DAT_ERSET; end
            3'd3: begin siCA = ADR_KEY1; siCD = DAT_KEY1;  end
            3'd4: begin siCA = ADR_KEY2; siCD = DAT_KEY2;  end
            default: begin
              siLast = 1'b1;
              if (opReg == OP_SECT) begin
                siA  = A_TGT;
                siCD = DAT_SECT;
              end else begin
                siCA = ADR_KEY1;
                siCD = DAT_CHIP;
              end
            end
          endcase
        end
        OP_CFI: begin
          if (step == 3'd0) begin
            siCA = ADR_QUERY;
            siCD = DAT_QUERY;
          end else begin
            siRead = 1'b1;
            siCA   = ADR_QBASE + 12'(step) - 12'd1;
            siLast = (step == 3'd4);
          end
        end
        default: siLast = 1'b1;
      endcase
    end
  end

  always_comb begin
    stateNx     = state;
    stepNx      = step;
    ctl         = '0;
    ctl.isRead  = siRead;
    ctl.aSel    = siA;
    ctl.dSel    = siD;
    ctl.cmdAddr = siCA;
    ctl.cmdData = siCD;
    case (state)
      S_IDLE: begin
        if (reqValid && !badReq) begin
          ctl.latch = 1'b1;
          stepNx    = 3'd0;
          stateNx   = S_LAUNCH;
        end
      end
      S_LAUNCH: begin
        ctl.start = 1'b1;
        stateNx   = S_RUN;
      end
      S_RUN: begin
        if (cycDone) begin
          if (siLast) begin
            stateNx = S_IDLE;
          end else if ((opReg == OP_BUF) && (step == 3'd4) && !wordLast) begin
            ctl.incWord = 1'b1;
            stateNx     = S_WAITW;
          end else begin
            stepNx  = step + 3'd1;
            stateNx = ((opReg == OP_BUF) && (step == 3'd3)) ? S_WAITW : S_LAUNCH;
          end
        end
      end
      default: begin
        if (reqValid) begin
          ctl.loadWord = 1'b1;
          stateNx      = S_LAUNCH;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      step  <= 3'd0;
      opReg <= OP_RESET;
      errQ  <= 1'b0;
    end else begin
      state <= stateNx;
      step  <= stepNx;
      errQ  <= (state == S_IDLE) && reqValid && badReq;
      if (ctl.latch) opReg <= opT'(reqOp);
    end
  end

  assign reqReady = (state == S_IDLE) || (state == S_WAITW);
  assign busy     = (state != S_IDLE);
  assign reqNack  = reqValid && !reqReady;
  assign reqErr   = errQ;

endmodule

// File: rtl/nor_seq_dp.sv
module nor_seq_dp
  import nor_seq_pkg::*;
#(
  parameter int AW            = 20,
  parameter int CW            = 6,
  parameter int HOLD          = 4,
  parameter int PULSE         = 2,
  parameter bit HALFWORD_BUS  = 1'b1
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctlStrobeT     ctl,
  input  logic [AW-1:0] reqAddr,
  input  logic [CW-1:0] reqCount,
  input  logic [15:0]   reqData,
  input  logic [15:0]   busRdData,
  output logic [AW:0]   busAddr,
  output logic [15:0]   busWrData,
  output logic          busWe,
  output logic          busRe,
  output logic          rdValid,
  output logic [15:0]   rdData,
  output logic          cycDone,
  output logic          wordLast
);

  localparam int CYW = $clog2(HOLD + 1);

  logic [AW-1:0]  tgtReg, addrQ, addrNx;
  logic [CW-1:0]  cntReg, wordIdx;
  logic [15:0]    reqDReg, wordReg, dataQ, dataNx;
  logic [CYW-1:0] cyc;
  logic           active, isRd, strobeOn, sampleNow;

  always_comb begin
    case (ctl.aSel)
      A_TGT:   addrNx = tgtReg;
      A_WORD:  addrNx = tgtReg + AW'(wordIdx);
      A_LAST:  addrNx = tgtReg + AW'(cntReg - CW'(1));
      default: addrNx = AW'(ctl.cmdAddr);
    endcase
    case (ctl.dSel)
      D_CNTM1: dataNx = 16'(cntReg - CW'(1));
      D_WORD:  dataNx = wordReg;
      D_REQ:   dataNx = reqDReg;
      default: dataNx = {8'h00, ctl.cmdData};
    endcase
  end

  assign cycDone   = active && (cyc == CYW'(HOLD - 1));
  assign strobeOn  = active && (cyc != '0) && (cyc <= CYW'(PULSE));
  assign sampleNow = active && isRd && (cyc == CYW'(PULSE));
  assign wordLast  = (wordIdx == (cntReg - CW'(1)));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tgtReg  <= '0;
      cntReg  <= '0;
      wordIdx <= '0;
      reqDReg <= '0;
      wordReg <= '0;
      addrQ   <= '0;
      dataQ   <= '0;
      cyc     <= '0;
      active  <= 1'b0;
      isRd    <= 1'b0;
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      if (ctl.latch) begin
        tgtReg  <= reqAddr;
        cntReg  <= reqCount;
        reqDReg <= reqData;
        wordIdx <= '0;
      end
      if (ctl.incWord) wordIdx <= wordIdx + CW'(1);
      if (ctl.loadWord) wordReg <= reqData;
      if (ctl.start) begin
        active <= 1'b1;
        cyc    <= '0;
        isRd   <= ctl.isRead;
        addrQ  <= addrNx;
        dataQ  <= dataNx;
      end else if (active) begin
        if (cycDone) active <= 1'b0;
        else         cyc    <= cyc + CYW'(1);
      end
      rdValid <= sampleNow;
      if (sampleNow) rdData <= busRdData;
    end
  end

  generate
    if (HALFWORD_BUS) begin : g_half
      assign busAddr = {addrQ, 1'b0};
    end else begin : g_byte
      assign busAddr = {1'b0, addrQ};
    end
  endgenerate

  assign busWrData = dataQ;
  assign busWe     = strobeOn && !isRd;
  assign busRe     = strobeOn && isRd;

endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
  import nor_seq_pkg::*;
#(
  parameter int AW      = 20,
  parameter int CW      = 6,
  parameter int MAX_BUF = 32,
  parameter int HOLD    = 4,
  parameter int PULSE   = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqValid,
  output logic          reqReady,
  input  logic [2:0]    reqOp,
  input  logic [AW-1:0] reqAddr,
  input  logic [CW-1:0] reqCount,
  input  logic [15:0]   reqData,
  output logic          reqNack,
  output logic          reqErr,
  output logic          busy,
  output logic [AW:0]   busAddr,
  output logic [15:0]   busWrData,
  output logic          busWe,
  output logic          busRe,
  input  logic [15:0]   busRdData,
  output logic          rdValid,
  output logic [15:0]   rdData
);

  ctlStrobeT ctl;
  logic      cycDone, wordLast;

  nor_seq_ctrl #(.CW(CW), .MAX_BUF(MAX_BUF)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .reqCount(reqCount), .cycDone(cycDone), .wordLast(wordLast),
    .reqReady(reqReady), .reqNack(reqNack), .reqErr(reqErr),
    .busy(busy), .ctl(ctl)
  );

  nor_seq_dp #(.AW(AW), .CW(CW), .HOLD(HOLD), .PULSE(PULSE), .HALFWORD_BUS(1'b1)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .reqAddr(reqAddr),
    .reqCount(reqCount), .reqData(reqData), .busRdData(busRdData),
    .busAddr(busAddr), .busWrData(busWrData), .busWe(busWe), .busRe(busRe),
    .rdValid(rdValid), .rdData(rdData), .cycDone(cycDone), .wordLast(wordLast)
  );

endmodule

// File: rtl/nor_cmd_seq_chk.sv
module nor_cmd_seq_chk #(
  parameter int AW    = 20,
  parameter int PULSE = 2
) (
  input logic          clk,
  input logic          rstN,
  input logic          reqValid,
  input logic          reqReady,
  input logic          busy,
  input logic          reqErr,
  input logic          busWe,
  input logic          busRe,
  input logic [AW:0]   busAddr,
  input logic [15:0]   busWrData,
  input logic          rdValid
);

  logic [7:0] hiCnt;
  logic       strb;

  assign strb = busWe || busRe;

  always_ff @(posedge clk) begin
    if (!rstN)     hiCnt <= 8'd0;
    else if (strb) hiCnt <= hiCnt + 8'd1;
    else           hiCnt <= 8'd0;
  end

  p_one_strobe_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(busWe && busRe));

  p_stable_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strb && $past(strb)) |-> ($stable(busAddr) && $stable(busWrData)));

  p_pulse_max_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb |-> (int'(hiCnt) < PULSE));

  p_pulse_full_r2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(strb) |-> (int'(hiCnt) == PULSE));

  p_rd_after_strobe_r4: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> $past(busRe));

  p_start_needs_accept_r10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(reqValid && reqReady));

  p_ready_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !strb);

  p_err_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    reqErr |-> (!busy && !strb));

endmodule

bind nor_cmd_seq nor_cmd_seq_chk #(.AW(AW), .PULSE(PULSE)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .busy(busy), .reqErr(reqErr), .busWe(busWe), .busRe(busRe),
  .busAddr(busAddr), .busWrData(busWrData), .rdValid(rdValid)
);

// File: tb/nor_cmd_seq_tb.sv
`timescale 1ns/1ps
module nor_cmd_seq_tb;

  localparam int AW = 20, CW = 6, MAX_BUF = 32, HOLD = 4, PULSE = 2;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic          reqReady;
  logic [2:0]    reqOp = 3'd0;
  logic [AW-1:0] reqAddr = '0;
  logic [CW-1:0] reqCount = '0;
  logic [15:0]   reqData = '0;
  logic          reqNack, reqErr, busy;
  logic [AW:0]   busAddr;
  logic [15:0]   busWrData, busRdData, rdData;
  logic          busWe, busRe, rdValid;

  always #2 clk = ~clk;

  function automatic logic [15:0] flashWord(int byteAddr);
    return 16'(byteAddr * 37 + 4660);
  endfunction

  assign busRdData = flashWord(int'(busAddr));

  nor_cmd_seq #(.AW(AW), .CW(CW), .MAX_BUF(MAX_BUF), .HOLD(HOLD), .PULSE(PULSE)) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqOp(reqOp), .reqAddr(reqAddr), .reqCount(reqCount), .reqData(reqData),
    .reqNack(reqNack), .reqErr(reqErr), .busy(busy), .busAddr(busAddr),
    .busWrData(busWrData), .busWe(busWe), .busRe(busRe), .busRdData(busRdData),
    .rdValid(rdValid), .rdData(rdData)
  );

  int nChecks = 0, nFail = 0;
  string curTag = "R1";
  bit finished = 1'b0;

  // reference model: expected bus cycles and read results
  int eKind[$], eAddr[$], eData[$];
  int rdExp[$];

  task automatic chk(bit ok, string req, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic expW(int wa, int d);
    eKind.push_back(0); eAddr.push_back(wa); eData.push_back(d);
  endtask

  task automatic expR(int wa);
    eKind.push_back(1); eAddr.push_back(wa); eData.push_back(0);
    rdExp.push_back(int'(flashWord(wa * 2)));
  endtask

  task automatic expUnlock();
    expW(32'h555, 32'hAA);
    expW(32'h2AA, 32'h55);
  endtask

  // per-clock comparison of the bus against the model
  bit   prevStrb = 1'b0;
  int   width = 0;
  logic [AW:0] holdA;
  logic [15:0] holdD;

  always @(negedge clk) begin
    if (rstN) begin
      bit strb;
      strb = busWe || busRe;
      if (strb && !prevStrb) begin
        if (eKind.size() == 0) begin
          chk(1'b0, {curTag, " unexpected bus cycle"}, int'(busAddr), -1);
        end else begin
          int k, a, d;
          k = eKind.pop_front(); a = eAddr.pop_front(); d = eData.pop_front();
          chk(int'(busRe) == k, {curTag, " cycle kind"}, int'(busRe), k);
          chk(int'(busAddr) == a * 2, "R12 byte address", int'(busAddr), a * 2);
          if (k == 0) chk(int'(busWrData) == d, {curTag, " write data"}, int'(busWrData), d);
        end
        holdA = busAddr;
        holdD = busWrData;
        width = 1;
      end else if (strb) begin
        width++;
        chk(busAddr == holdA && busWrData == holdD, "R2 hold", int'(busAddr), int'(holdA));
      end else if (prevStrb) begin
        chk(width == PULSE, "R2 strobe width", width, PULSE);
      end
      if (busWe && busRe) chk(1'b0, "R2 both strobes", 1, 0);
      if (rdValid) begin
        if (rdExp.size() == 0) chk(1'b0, {curTag, " unexpected read word"}, int'(rdData), -1);
        else begin
          int e;
          e = rdExp.pop_front();
          chk(int'(rdData) == e, {curTag, " read word"}, int'(rdData), e);
        end
      end
      prevStrb = strb;
    end
  end

  task automatic sendBeat(int op, int addr, int cnt, int data);
    @(negedge clk);
    reqValid = 1'b1;
    reqOp    = 3'(op);
    reqAddr  = AW'(addr);
    reqCount = CW'(cnt);
    reqData  = 16'(data);
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic waitIdle();
    @(negedge clk);
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(eKind.size() == 0, {curTag, " cycles left over"}, eKind.size(), 0);
    chk(rdExp.size() == 0, {curTag, " reads left over"}, rdExp.size(), 0);
  endtask

  task automatic runBuf(int addr, int cnt);
    curTag = "R6";
    expUnlock();
    expW(addr, 32'h25);
    expW(addr, cnt - 1);
    for (int i = 0; i < cnt; i++) expW(addr + i, 32'h1000 + i * 3);
    expW(addr + cnt - 1, 32'h29);
    sendBeat(3, addr, cnt, 0);
    for (int i = 0; i < cnt; i++) sendBeat(0, 0, cnt, 32'h1000 + i * 3);
    waitIdle();
  endtask

  task automatic badReq(string tag, int op, int cnt);
    curTag = tag;
    sendBeat(op, 32'h100, cnt, 0);
    chk(reqErr == 1'b1, {tag, " error pulse"}, int'(reqErr), 1);
    chk(busy == 1'b0, {tag, " stays idle"}, int'(busy), 0);
    repeat (12) @(negedge clk);
    chk(busy == 1'b0 && reqErr == 1'b0, {tag, " no activity"}, int'(busy), 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    curTag = "R1";
    chk(busy == 1'b0, "R1 busy", int'(busy), 0);
    chk(reqReady == 1'b1, "R1 ready", int'(reqReady), 1);
    chk(!busWe && !busRe, "R1 strobes", int'(busWe || busRe), 0);
    chk(!rdValid && !reqErr, "R1 flags", int'(rdValid || reqErr), 0);

    curTag = "R3";
    expW(0, 32'hF0);
    sendBeat(0, 32'h777, 0, 0);
    waitIdle();

    curTag = "R4";
    expUnlock(); expW(32'h555, 32'h90);
    expR(0); expR(1); expR(32'hE); expR(32'hF);
    sendBeat(1, 0, 0, 0);
    waitIdle();

    curTag = "R5";
    expUnlock(); expW(32'h555, 32'hA0); expW(32'h1234, 32'hBEEF);
    sendBeat(2, 32'h1234, 0, 32'hBEEF);
    chk(reqErr == 1'b0, "R11 no error on valid request", int'(reqErr), 0);
    waitIdle();

    runBuf(32'h2000, 3);
    runBuf(32'h4100, 1);
    runBuf(32'h30000, MAX_BUF);

    curTag = "R7";
    expUnlock(); expW(32'h555, 32'h80); expW(32'h555, 32'hAA); expW(32'h2AA, 32'h55);
    expW(32'h40000, 32'h30);
    sendBeat(4, 32'h40000, 0, 0);
    waitIdle();

    curTag = "R8";
    expUnlock(); expW(32'h555, 32'h80); expW(32'h555, 32'hAA); expW(32'h2AA, 32'h55);
    expW(32'h555, 32'h10);
    sendBeat(5, 32'h9999, 0, 0);
    waitIdle();

    curTag = "R9";
    expW(32'h55, 32'h98);
    expR(32'h10); expR(32'h11); expR(32'h12); expR(32'h13);
    sendBeat(6, 0, 0, 0);
    waitIdle();

    // R10: request while a sector erase runs
    curTag = "R10";
    expUnlock(); expW(32'h555, 32'h80); expW(32'h555, 32'hAA); expW(32'h2AA, 32'h55);
    expW(32'h8000, 32'h30);
    sendBeat(4, 32'h8000, 0, 0);
    repeat (3) @(negedge clk);
    reqValid = 1'b1; reqOp = 3'd2; reqAddr = AW'(32'h5555); reqData = 16'h1111;
    @(negedge clk);
    chk(reqReady == 1'b0, "R10 ready low while busy", int'(reqReady), 0);
    chk(reqNack == 1'b1, "R10 nack", int'(reqNack), 1);
    @(negedge clk);
    reqValid = 1'b0;
    waitIdle();
    repeat (12) @(negedge clk);
    chk(busy == 1'b0, "R10 refused request not run", int'(busy), 0);

    badReq("R11 count over max", 3, MAX_BUF + 1);
    badReq("R11 count zero", 3, 0);
    badReq("R11 undefined opcode", 7, 1);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog %s actual=%0h expected=%0h", curTag, 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
      $finish;
    end
  end

endmodule